// File: doc/BRIEF.md
# Processor-Side I/O Port with Memory Overlay Decoder

This block places an 8-bit bidirectional port on the processor bus at the two lowest addresses. One register sets the direction of each pin and the other holds the value to drive. A pin whose direction bit is 1 drives the stored value. A pin whose direction bit is 0 is an input, and reads return the level on that pin. Because the two registers sit at those addresses, addresses 0 and 1 never reach RAM.

The two lowest port bits also steer a memory-map decoder, which produces one chip select each for RAM, ROM A, ROM B and the I/O window. Each ROM can be swapped out for the RAM underneath it, and when both steering bits are low the I/O window goes away as well, leaving the whole 64K as RAM. A steering bit whose pin is configured as an input counts as 1, as if a pull-up held it high, so both ROMs are visible after reset. Writes that land in a ROM region go to the RAM below it.

Top module: `cpu_port_bank`

## Requirements
- R1: After reset the direction and data registers are both 0x00, every pin is an input (pin_oe_o = 0x00, pin_out_o = 0x00), and ROM A, ROM B and the I/O window are all selected for reads in their ranges.
- R2: A write to address 0x0000 loads the direction register on the clock edge of that cycle, and pin_oe_o follows it bit for bit. A read of address 0x0000 returns the register's value.
- R3: A write to address 0x0001 loads the data register on the clock edge of that cycle, and pin_out_o shows its value.
- R4: A read of address 0x0001 returns, for each bit, the data register bit when the direction bit is 1 and the pin level when it is 0. Bit 4 (mask 0x10) configured as an input reports the external switch level.
- R5: Addresses 0x0000 and 0x0001 assert port_hit_o and assert no chip select. Every other address deasserts port_hit_o, and rdata_o is 0x00 there.
- R6: Effective steering bit k (k = 0, 1) is the data bit when direction bit k is 1, and 1 otherwise. Reads in 0xA000–0xBFFF select ROM A when effective bit 0 is 1, and RAM otherwise.
- R7: Reads in 0xE000–0xFFFF select ROM B when effective bit 1 is 1, and RAM otherwise.
- R8: Accesses in 0xD000–0xDFFF, reads or writes, select the I/O window when effective bit 0 or effective bit 1 is 1, and RAM otherwise.
- R9: Writes in 0xA000–0xBFFF or 0xE000–0xFFFF select RAM and never a ROM.
- R10: Every address from 0x0002 up that lies outside the ROM and I/O ranges selects RAM, and at most one chip select is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe for the current cycle |
| pin_in_i | input | 8 | Levels sensed on the port pins |
| pin_out_o | output | 8 | Values driven onto the port pins |
| pin_oe_o | output | 8 | Per-pin output enable |
| rdata_o | output | 8 | Read data for the port registers |
| port_hit_o | output | 1 | Address falls on a port register |
| cs_ram_o | output | 1 | RAM select |
| cs_rom_a_o | output | 1 | ROM A select |
| cs_rom_b_o | output | 1 | ROM B select |
| cs_io_o | output | 1 | I/O window select |

## Verification
A corrupted direction or data bit shows up on pin_oe_o or pin_out_o in the cycle after the write that caused it. It also changes the read-back of address 0 or 1 at once, and if the bit is one of the two steering bits it moves the ROM, RAM and I/O selects in their ranges within the same cycle. The bench walks every combination of the two steering bits' direction and data values against page boundaries, for both reads and writes. This exposes a wrong pull-up default, a swapped steering bit or a missed write-through as a mismatched chip select. A sweep over all 256 direction values with several pin patterns catches any fault in the read-back mux.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
  localparam int BANK_W = 2;

  typedef enum logic [2:0] {
    RGN_PORT,
    RGN_RAM,
    RGN_ROM_A,
    RGN_ROM_B,
    RGN_IO
  } region_e;
endpackage

// File: rtl/port_regs.sv
module port_regs #(
  parameter int PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_we_i,
  input  logic              dat_we_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      dat_o <= '0;
    end else begin
      if (dir_we_i) dir_o <= wdata_i;
      if (dat_we_i) dat_o <= wdata_i;
    end
  end

  a_r2_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dir_we_i) |-> dir_o == $past(wdata_i));
  a_r3_dat_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dat_we_i) |-> dat_o == $past(wdata_i));
  a_r2_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dir_we_i) |-> $stable(dir_o));
endmodule

// File: rtl/port_pins.sv
module port_pins
  import cpu_port_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic [PORT_W-1:0] dir_i,
  input  logic [PORT_W-1:0] dat_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] oe_o,
  output logic [PORT_W-1:0] rd_o,
  output logic [BANK_W-1:0] bank_o
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign oe_o[i]  = dir_i[i];
    assign pin_o[i] = dat_i[i];
    assign rd_o[i]  = dir_i[i] ? dat_i[i] : pin_i[i];
  end

  // undriven steering bits read high (pull-up)
  for (genvar k = 0; k < BANK_W; k++) begin : g_bank
    assign bank_o[k] = dir_i[k] ? dat_i[k] : 1'b1;
  end
endmodule

// File: rtl/bank_decode.sv
module bank_decode
  import cpu_port_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] ROMA_LO = 16'hA000,
  parameter logic [15:0] ROMA_HI = 16'hBFFF,
  parameter logic [15:0] IO_LO   = 16'hD000,
  parameter logic [15:0] IO_HI   = 16'hDFFF,
  parameter logic [15:0] ROMB_LO = 16'hE000,
  parameter logic [15:0] ROMB_HI = 16'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              port_hit_o,
  output logic              cs_ram_o,
  output logic              cs_rom_a_o,
  output logic              cs_rom_b_o,
  output logic              cs_io_o
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ROMA_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ROMA_HI);
  localparam logic [ADDR_W-1:0] B_LO = ADDR_W'(ROMB_LO);
  localparam logic [ADDR_W-1:0] B_HI = ADDR_W'(ROMB_HI);
  localparam logic [ADDR_W-1:0] I_LO = ADDR_W'(IO_LO);
  localparam logic [ADDR_W-1:0] I_HI = ADDR_W'(IO_HI);

  region_e rgn;
  logic    in_a, in_b, in_io, in_port;

  assign in_port = (addr_i[ADDR_W-1:1] == '0);
  assign in_a    = (addr_i >= A_LO) && (addr_i <= A_HI);
  assign in_b    = (addr_i >= B_LO) && (addr_i <= B_HI);
  assign in_io   = (addr_i >= I_LO) && (addr_i <= I_HI);

  always_comb begin
    rgn = RGN_RAM;
    if (in_port)                       rgn = RGN_PORT;
    else if (in_a && bank_i[0] && !we_i) rgn = RGN_ROM_A;
    else if (in_b && bank_i[1] && !we_i) rgn = RGN_ROM_B;
    else if (in_io && (|bank_i))       rgn = RGN_IO;
  end

  assign port_hit_o = (rgn == RGN_PORT);
  assign cs_ram_o   = (rgn == RGN_RAM);
  assign cs_rom_a_o = (rgn == RGN_ROM_A);
  assign cs_rom_b_o = (rgn == RGN_ROM_B);
  assign cs_io_o    = (rgn == RGN_IO);
endmodule

// File: rtl/cpu_port_bank.sv
module cpu_port_bank
  import cpu_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic [PORT_W-1:0] pin_in_i,
  output logic [PORT_W-1:0] pin_out_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] rdata_o,
  output logic              port_hit_o,
  output logic              cs_ram_o,
  output logic              cs_rom_a_o,
  output logic              cs_rom_b_o,
  output logic              cs_io_o
);
  logic [PORT_W-1:0] dir_q, dat_q, rd_pin;
  logic [BANK_W-1:0] bank;
  logic              hit;

  port_regs #(.PORT_W(PORT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_we_i(we_i && hit && !addr_i[0]),
    .dat_we_i(we_i && hit &&  addr_i[0]),
    .wdata_i (wdata_i),
    .dir_o   (dir_q),
    .dat_o   (dat_q)
  );

  port_pins #(.PORT_W(PORT_W)) u_pins (
    .dir_i (dir_q),
    .dat_i (dat_q),
    .pin_i (pin_in_i),
    .pin_o (pin_out_o),
    .oe_o  (pin_oe_o),
    .rd_o  (rd_pin),
    .bank_o(bank)
  );

  bank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .we_i      (we_i),
    .bank_i    (bank),
    .port_hit_o(hit),
    .cs_ram_o  (cs_ram_o),
    .cs_rom_a_o(cs_rom_a_o),
    .cs_rom_b_o(cs_rom_b_o),
    .cs_io_o   (cs_io_o)
  );

  assign port_hit_o = hit;
  assign rdata_o    = !hit ? '0 : (addr_i[0] ? rd_pin : dir_q);

  a_r5_port_no_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < ADDR_W'(2)) |-> !(cs_ram_o || cs_rom_a_o || cs_rom_b_o || cs_io_o));
  a_r10_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_ram_o, cs_rom_a_o, cs_rom_b_o, cs_io_o}));
  a_r10_some_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_hit_o |-> $countones({cs_ram_o, cs_rom_a_o, cs_rom_b_o, cs_io_o}) == 1);
  a_r9_no_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !(cs_rom_a_o || cs_rom_b_o));
  a_r8_io_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_io_o |-> (!pin_oe_o[0] || pin_out_o[0] || !pin_oe_o[1] || pin_out_o[1]));
  a_r6_roma_needs_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rom_a_o |-> (!pin_oe_o[0] || pin_out_o[0]));
  a_r7_romb_needs_bit1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rom_b_o |-> (!pin_oe_o[1] || pin_out_o[1]));
endmodule

// File: tb/cpu_port_bank_tb.sv
module cpu_port_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe, rdata;
  logic        hit, cs_ram, cs_a, cs_b, cs_io;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  cpu_port_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .rdata_o(rdata),
    .port_hit_o(hit), .cs_ram_o(cs_ram), .cs_rom_a_o(cs_a), .cs_rom_b_o(cs_b),
    .cs_io_o(cs_io)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0; addr = 16'h0002;
  endtask

  // {hit, ram, rom_a, rom_b, io}
  function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic w,
                                         input logic [7:0] d, input logic [7:0] q);
    logic e0, e1;
    e0 = d[0] ? q[0] : 1'b1;
    e1 = d[1] ? q[1] : 1'b1;
    if (a < 16'd2)                             return 5'b10000;
    if (a >= 16'hA000 && a <= 16'hBFFF && e0 && !w) return 5'b00100;
    if (a >= 16'hE000 && e1 && !w)             return 5'b00010;
    if (a >= 16'hD000 && a <= 16'hDFFF && (e0 || e1)) return 5'b00001;
    return 5'b01000;
  endfunction

  task automatic chk_sel(input string req, input logic [15:0] a, input logic w,
                         input logic [7:0] d, input logic [7:0] q);
    @(negedge clk);
    addr = a; we = w; wdata = 8'h00;
    #1;
    chk(req, {11'd0, hit, cs_ram, cs_a, cs_b, cs_io}, {11'd0, exp_sel(a, w, d, q)});
    we = 1'b0;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    pin_in = 8'hAA; addr = 16'h0000; #1;
    chk("R1 oe", {8'd0, pin_oe}, 16'h0000);
    chk("R1 out", {8'd0, pin_out}, 16'h0000);
    chk("R1 dir read", {8'd0, rdata}, 16'h0000);
    addr = 16'h0001; #1;
    chk("R1 pin read", {8'd0, rdata}, 16'h00AA);
    chk_sel("R1 rom a", 16'hA000, 1'b0, 8'h00, 8'h00);
    chk_sel("R1 rom b", 16'hE000, 1'b0, 8'h00, 8'h00);
    chk_sel("R1 io", 16'hD000, 1'b0, 8'h00, 8'h00);

    // R2 / R3: register loads and pin outputs
    wr(16'h0000, 8'h3C);
    @(negedge clk); addr = 16'h0000; #1;
    chk("R2 oe", {8'd0, pin_oe}, 16'h003C);
    chk("R2 read", {8'd0, rdata}, 16'h003C);
    wr(16'h0001, 8'hA5);
    @(negedge clk); #1;
    chk("R3 out", {8'd0, pin_out}, 16'h00A5);
    chk("R2 oe kept", {8'd0, pin_oe}, 16'h003C);

    // R4: read mux, all direction values against several pin patterns
    wr(16'h0001, 8'hC3);
    for (int dv = 0; dv < 256; dv++) begin
      wr(16'h0000, 8'(dv));
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pv;
        pv = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5A;
        @(negedge clk);
        pin_in = pv; addr = 16'h0001; #1;
        chk("R4 mix", {8'd0, rdata}, {8'd0, (8'(dv) & 8'hC3) | (~8'(dv) & pv)});
        chk("R2 oe", {8'd0, pin_oe}, {8'd0, 8'(dv)});
      end
    end

    // R4: switch sense on bit 4
    wr(16'h0000, 8'h00);
    @(negedge clk); pin_in = 8'h10; addr = 16'h0001; #1;
    chk("R4 switch hi", {8'd0, rdata & 8'h10}, 16'h0010);
    pin_in = 8'hEF; #1;
    chk("R4 switch lo", {8'd0, rdata & 8'h10}, 16'h0000);

    // R5: no read data off the port addresses
    addr = 16'h0002; #1;
    chk("R5 rdata", {8'd0, rdata}, 16'h0000);

    // R5-R10: all steering configurations over page edges, reads and writes
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [7:0] dv, qv;
      dv = {6'd0, 2'(cfg)};
      qv = {6'b101010, 2'(cfg >> 2)};
      wr(16'h0000, dv);
      wr(16'h0001, qv);
      for (int pg = 0; pg < 256; pg++) begin
        for (int o = 0; o < 3; o++) begin
          a = {8'(pg), (o == 0) ? 8'h00 : (o == 1) ? 8'h01 : 8'hFF};
          chk_sel("R5/R6/R7/R8/R10 read", a, 1'b0, dv, qv);
          if (a >= 16'h0002)
            chk_sel("R9/R8/R10 write", a, 1'b1, dv, qv);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule